// File: doc/BRIEF.md
# Floating-Point Status and Exception Control Register

This block holds the status and control word of a floating-point unit. Software loads the word with a 32-bit write. Only the writable bits are stored. The stored word then drives two control outputs for the arithmetic datapath: a round-toward-zero select and a flush-to-zero select. The arithmetic itself lives elsewhere.

After each arithmetic operation, the datapath presents a five-bit vector of raw exception conditions. The block replaces the sticky-free flag field with that vector and ORs the same bits into a cause field, where they accumulate. If any accumulated cause bit is also enabled, the block pulses a trap request that carries the fixed exception code 0x120. A compare can also complete. An unordered compare applies the same update. An ordered compare leaves the word alone.

Word layout: bits 1:0 hold the rounding mode, bits 6:2 the flags, bits 11:7 the enables, bits 16:12 the cause and bit 18 the denormal-flush select. Bit 17 and bits 31:19 read as zero. Inside each five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. The raw exception input uses the same order.

Top module: `fp_status_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `regValue` is 0, `roundZero` and `flushZero` are 0, `trapReq` is 0 and `trapCode` is 0.
- R2: A write (`wrEn`=1) stores `wrData & 32'h0005_FFFF`, which is visible on `regValue` after the next rising edge.
- R3: `roundZero` is 1 exactly when `regValue[1:0]` is 2'b01. The encodings 2'b00, 2'b10 and 2'b11 all give 0, which means round-to-nearest-even.
- R4: `flushZero` equals `regValue[18]`, the denormal-flush bit.
- R5: An update without a write sets `regValue[6:2]` to exactly `opExc`, so any previous flag bits are cleared. The rounding bits, the enable bits 11:7 and bit 18 are unchanged.
- R6: On the same update, `regValue[16:12]` becomes its previous value ORed with `opExc`, so cause bits accumulate across operations.
- R7: When an update leaves `(cause & enable)` nonzero, `trapReq` is 1 for exactly one cycle, the cycle after the update edge. During that cycle `trapCode` is 12'h120; at all other times `trapCode` is 0. The updated word is kept. The trap test uses the accumulated cause, not the raw flags.
- R8: An update happens when `opDone`=1, or when `cmpDone`=1 with `cmpUnordered`=1. A compare with `cmpUnordered`=0 and no `opDone` leaves `regValue` unchanged and raises no trap.
- R9: If a write and an update occur in the same cycle, the write wins: `regValue` becomes the masked write data and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| opDone | input | 1 | Arithmetic operation completed this cycle |
| opExc | input | 5 | Raw exceptions of the completing operation (bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact) |
| cmpDone | input | 1 | Compare completed this cycle |
| cmpUnordered | input | 1 | The completing compare was unordered |
| regValue | output | 32 | Current status/control word |
| roundZero | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| flushZero | output | 1 | Flush denormals to zero |
| trapReq | output | 1 | One-cycle trap request |
| trapCode | output | 12 | Exception code, 12'h120 while `trapReq` is high |

## Verification
The assertions assume that the strobes and the exception vector are known, 0 or 1, on every clock edge from reset onward. They also assume that `opExc` is driven whenever an update can occur, so that `$past` of it is meaningful. The stimulus applies every vector at the falling edge, holds it for a full cycle, and keeps all inputs at zero during reset. Single-cycle strobes are separated by idle cycles where a trap pulse must be seen to end. The stimulus exercises writes and updates in the same cycle, ordered and unordered compares, and traps triggered only by cause bits that were accumulated earlier.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int CSR_W      = 32;
  localparam int EXC_W      = 5;
  localparam int CODE_W     = 12;
  localparam int RM_LSB     = 0;
  localparam int RM_W       = 2;
  localparam int FLAG_LSB   = 2;
  localparam int EN_LSB     = 7;
  localparam int CAUSE_LSB  = 12;
  localparam int DENORM_BIT = 18;
  localparam logic [CSR_W-1:0]  WR_MASK_DEF   = 32'h0005_FFFF;
  localparam logic [CODE_W-1:0] TRAP_CODE_DEF = 12'h120;
  localparam logic [RM_W-1:0]   RM_TO_ZERO    = 2'b01;

  typedef struct packed {
    logic load;
    logic update;
  } csrStrobe_t;
endpackage

// File: rtl/fp_status_dp.sv
module fp_status_dp
  import fp_status_pkg::*;
#(
  parameter logic [CSR_W-1:0] WR_MASK = WR_MASK_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [CSR_W-1:0] wrData,
  input  logic [EXC_W-1:0] opExc,
  output logic [CSR_W-1:0] csrQ,
  output logic             trapHit,
  output logic             roundZero,
  output logic             flushZero
);
  localparam int FLAG_MSB  = FLAG_LSB + EXC_W - 1;
  localparam int EN_MSB    = EN_LSB + EXC_W - 1;
  localparam int CAUSE_MSB = CAUSE_LSB + EXC_W - 1;

  logic [EXC_W-1:0] causeNext;
  logic [CSR_W-1:0] csrNext;

  assign causeNext = csrQ[CAUSE_MSB:CAUSE_LSB] | opExc;
  assign trapHit   = |(causeNext & csrQ[EN_MSB:EN_LSB]);

  always_comb begin
    csrNext = csrQ;
    if (strobe.load) begin
      csrNext = wrData & WR_MASK;
    end else if (strobe.update) begin
      csrNext[FLAG_MSB:FLAG_LSB]   = opExc;
      csrNext[CAUSE_MSB:CAUSE_LSB] = causeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) csrQ <= '0;
    else       csrQ <= csrNext;
  end

  assign roundZero = (csrQ[RM_LSB+RM_W-1:RM_LSB] == RM_TO_ZERO);
  assign flushZero = csrQ[DENORM_BIT];
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
#(
  parameter logic [CODE_W-1:0] TRAP_CODE = TRAP_CODE_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              opDone,
  input  logic              cmpDone,
  input  logic              cmpUnordered,
  input  logic              trapHit,
  output csrStrobe_t        strobe,
  output logic              trapReq,
  output logic [CODE_W-1:0] trapCode
);
  logic trapQ;

  // A write always wins over a same-cycle update.
  assign strobe.load   = wrEn;
  assign strobe.update = !wrEn && (opDone || (cmpDone && cmpUnordered));

  always_ff @(posedge clk) begin
    if (!rstN) trapQ <= 1'b0;
    else       trapQ <= strobe.update && trapHit;
  end

  assign trapReq  = trapQ;
  assign trapCode = trapQ ? TRAP_CODE : '0;
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
  import fp_status_pkg::*;
#(
  parameter logic [CSR_W-1:0]  WR_MASK   = WR_MASK_DEF,
  parameter logic [CODE_W-1:0] TRAP_CODE = TRAP_CODE_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CSR_W-1:0]  wrData,
  input  logic              opDone,
  input  logic [EXC_W-1:0]  opExc,
  input  logic              cmpDone,
  input  logic              cmpUnordered,
  output logic [CSR_W-1:0]  regValue,
  output logic              roundZero,
  output logic              flushZero,
  output logic              trapReq,
  output logic [CODE_W-1:0] trapCode
);
  csrStrobe_t strobe;
  logic       trapHit;

  fp_status_ctrl #(.TRAP_CODE(TRAP_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opDone(opDone),
    .cmpDone(cmpDone), .cmpUnordered(cmpUnordered), .trapHit(trapHit),
    .strobe(strobe), .trapReq(trapReq), .trapCode(trapCode)
  );

  fp_status_dp #(.WR_MASK(WR_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .opExc(opExc),
    .csrQ(regValue), .trapHit(trapHit), .roundZero(roundZero), .flushZero(flushZero)
  );
endmodule

// File: rtl/fp_status_chk.sv
module fp_status_chk
  import fp_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CSR_W-1:0]  wrData,
  input logic              opDone,
  input logic [EXC_W-1:0]  opExc,
  input logic              cmpDone,
  input logic              cmpUnordered,
  input logic [CSR_W-1:0]  regValue,
  input logic              roundZero,
  input logic              flushZero,
  input logic              trapReq,
  input logic [CODE_W-1:0] trapCode
);
  logic upd;
  assign upd = !wrEn && (opDone || (cmpDone && cmpUnordered));

  // R2 and R9: a write is stored masked, whatever else happens in that cycle
  assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regValue == ($past(wrData) & WR_MASK_DEF));

  // R9: no trap follows a write cycle
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !trapReq);

  // R5: flags replaced by the raw vector, control fields kept
  assert_flag_replace_R5: assert property (@(posedge clk) disable iff (!rstN)
    upd |=> (regValue[6:2] == $past(opExc)) &&
            (regValue[11:7] == $past(regValue[11:7])) &&
            (regValue[1:0] == $past(regValue[1:0])));

  // R6: cause accumulates
  assert_cause_accum_R6: assert property (@(posedge clk) disable iff (!rstN)
    upd |=> regValue[16:12] == ($past(regValue[16:12]) | $past(opExc)));

  // R7: a trap pulse follows only an update and only with an enabled cause
  assert_trap_cond_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ((regValue[16:12] & regValue[11:7]) != 5'd0) && $past(upd));

  assert_trap_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> trapCode == TRAP_CODE_DEF);

  assert_trap_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && !upd |=> !trapReq);

  // R8: an ordered compare alone changes nothing
  assert_ordered_cmp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !opDone && cmpDone && !cmpUnordered) |=> $stable(regValue) && !trapReq);

  // R3, R4: control outputs follow the stored word
  assert_ctrl_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    (roundZero == (regValue[1:0] == 2'b01)) && (flushZero == regValue[18]));
endmodule

bind fp_status_ctl fp_status_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .opDone(opDone),
  .opExc(opExc), .cmpDone(cmpDone), .cmpUnordered(cmpUnordered),
  .regValue(regValue), .roundZero(roundZero), .flushZero(flushZero),
  .trapReq(trapReq), .trapCode(trapCode)
);

// File: tb/sim_fp_status_ctl.sv
`timescale 1ns/1ps
module sim_fp_status_ctl;
  typedef struct {
    logic [31:0] value;
    logic        rz;
    logic        fz;
    logic        trap;
    logic [11:0] code;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opExc = '0;
  logic        cmpDone = 1'b0;
  logic        cmpUnordered = 1'b0;
  logic [31:0] regValue;
  logic        roundZero, flushZero, trapReq;
  logic [11:0] trapCode;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;
  logic [31:0] model = '0;
  expItem_t scoreQ[$];

  always #4 clk = ~clk;

  fp_status_ctl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .opDone(opDone),
    .opExc(opExc), .cmpDone(cmpDone), .cmpUnordered(cmpUnordered),
    .regValue(regValue), .roundZero(roundZero), .flushZero(flushZero),
    .trapReq(trapReq), .trapCode(trapCode)
  );

  task automatic compareItem(input expItem_t e);
    vectors++;
    if (regValue !== e.value || roundZero !== e.rz || flushZero !== e.fz ||
        trapReq !== e.trap || trapCode !== e.code) begin
      misses++;
      $display("FAIL %s: actual reg=%h rz=%b fz=%b trap=%b code=%h expected reg=%h rz=%b fz=%b trap=%b code=%h",
               e.tag, regValue, roundZero, flushZero, trapReq, trapCode,
               e.value, e.rz, e.fz, e.trap, e.code);
    end
  endtask

  // Monitor: results appear after the edge that followed the push.
  always @(negedge clk) begin
    if (scoreQ.size() > 0) compareItem(scoreQ.pop_front());
  end

  // Driver: apply one cycle of stimulus and predict the outcome.
  task automatic step(input logic w, input logic [31:0] d, input logic op,
                      input logic [4:0] e, input logic cmp, input logic unord,
                      input string tag);
    expItem_t it;
    logic trapE;
    @(negedge clk);
    wrEn = w; wrData = d; opDone = op; opExc = e; cmpDone = cmp; cmpUnordered = unord;
    trapE = 1'b0;
    if (w) begin
      model = d & 32'h0005_FFFF;
    end else if (op || (cmp && unord)) begin
      model[6:2]   = e;
      model[16:12] = model[16:12] | e;
      trapE = |(model[16:12] & model[11:7]);
    end
    @(posedge clk);
    it.value = model;
    it.rz    = (model[1:0] == 2'b01);
    it.fz    = model[18];
    it.trap  = trapE;
    it.code  = trapE ? 12'h120 : 12'h000;
    it.tag   = tag;
    scoreQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 5'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (regValue !== 32'd0 || roundZero !== 1'b0 || flushZero !== 1'b0 ||
        trapReq !== 1'b0 || trapCode !== 12'd0) begin
      misses++;
      $display("FAIL R1 reset: actual reg=%h rz=%b fz=%b trap=%b expected all zero",
               regValue, roundZero, flushZero, trapReq);
    end
    rstN = 1'b1;
    idle("R1 after reset");

    // R2 R3 R4: masking and control decoding
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 1'b0, "R2 mask all-ones");
    step(1'b1, 32'h0000_0001, 1'b0, 5'd0, 1'b0, 1'b0, "R3 round-to-zero");
    step(1'b1, 32'h0000_0002, 1'b0, 5'd0, 1'b0, 1'b0, "R3 mode 10 nearest");
    step(1'b1, 32'h0000_0003, 1'b0, 5'd0, 1'b0, 1'b0, "R3 mode 11 nearest");
    step(1'b1, 32'hFFF4_0000, 1'b0, 5'd0, 1'b0, 1'b0, "R4 flush bit");
    step(1'b1, 32'h0002_0000, 1'b0, 5'd0, 1'b0, 1'b0, "R2 reserved bit 17");

    // R5 R6: flag replacement and cause accumulation, no enables
    step(1'b1, 32'h0000_0001, 1'b0, 5'd0, 1'b0, 1'b0, "R5 setup");
    step(1'b0, '0, 1'b1, 5'b00001, 1'b0, 1'b0, "R5 inexact");
    step(1'b0, '0, 1'b1, 5'b10000, 1'b0, 1'b0, "R6 invalid accumulates");
    step(1'b0, '0, 1'b1, 5'b00000, 1'b0, 1'b0, "R5 flags cleared");

    // R7: trap from an enabled raw exception, then pulse ends
    step(1'b1, 32'h0000_0201, 1'b0, 5'd0, 1'b0, 1'b0, "R7 enable overflow");
    step(1'b0, '0, 1'b1, 5'b00100, 1'b0, 1'b0, "R7 overflow trap");
    idle("R7 pulse ends");
    // R7: no trap when raw exception not enabled
    step(1'b1, 32'h0000_0100, 1'b0, 5'd0, 1'b0, 1'b0, "R7 enable underflow only");
    step(1'b0, '0, 1'b1, 5'b00100, 1'b0, 1'b0, "R7 disabled overflow");
    // R7: trap from accumulated cause with zero raw vector
    step(1'b1, 32'h0000_1080, 1'b0, 5'd0, 1'b0, 1'b0, "R7 cause preset");
    step(1'b0, '0, 1'b1, 5'b00000, 1'b0, 1'b0, "R7 trap from cause");
    step(1'b0, '0, 1'b1, 5'b00000, 1'b0, 1'b0, "R7 back-to-back trap");
    idle("R7 idle after trap");

    // R8: compares
    step(1'b1, 32'h0000_0000, 1'b0, 5'd0, 1'b0, 1'b0, "R8 setup");
    step(1'b0, '0, 1'b0, 5'b10000, 1'b1, 1'b0, "R8 ordered compare");
    step(1'b0, '0, 1'b0, 5'b10000, 1'b1, 1'b1, "R8 unordered compare");
    step(1'b1, 32'h0000_0800, 1'b0, 5'd0, 1'b0, 1'b0, "R8 enable invalid");
    step(1'b0, '0, 1'b0, 5'b10000, 1'b1, 1'b1, "R8 unordered trap");

    // R9: write beats update in the same cycle
    step(1'b1, 32'h0000_0F80, 1'b1, 5'b11111, 1'b0, 1'b0, "R9 write and op");
    step(1'b1, 32'h0000_0F80, 1'b0, 5'b11111, 1'b1, 1'b1, "R9 write and compare");
    idle("R9 idle");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule